// File: doc/BRIEF.md
# ECC Error Address Capture Register

This block sits beside the SECDED checker on a memory read path and keeps a record of the first ECC event it sees. It stores one 32-bit status word. The word holds the upper bits of the failing address and the syndrome of a corrected error. It also holds two sticky flags, one for a single-bit event and one for a multi-bit event. Three control bits live in the same word. They select whether corrected reads trigger a write-back scrub, whether a logged single-bit error raises an NMI request, and whether a logged multi-bit error raises a system-error request.

Software reads the word, handles the event, and then writes ones to the flag bits to re-arm the logger. Until both flags are clear, the stored address and syndrome stay frozen and any new event is dropped. Scrub requests are not affected by the logging state. They follow every corrected read while scrubbing is enabled.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, `rd_data_o` reads all zero and `scrub_req_o`, `nmi_o` and `serr_o` are low.
- R2: Bit 31 disables scrubbing. While it is 0, each cycle with `ce_i` high produces `scrub_req_o` high for exactly the following cycle. While it is 1, `scrub_req_o` stays low.
- R3: Bits 30:12 hold `err_addr_i[31:13]` of the logged event. Writes do not change them.
- R4: Bits 11:4 hold the 8-bit `err_syn_i` of a logged single-bit event. Writes do not change them.
- R5: Bit 0 flags a single-bit event and bit 1 flags a multi-bit event. The two are never set together; the type logged first is the only one set.
- R6: Writing 1 to bit 0 or bit 1 clears that flag, and writing 0 leaves it unchanged. A new event is logged only when both flags are clear.
- R7: While either flag is set, new events on `ce_i` or `ue_i` leave the flags, address and syndrome unchanged.
- R8: A logged multi-bit event stores a syndrome of zero.
- R9: If `ce_i` and `ue_i` are high in the same cycle while the logger is armed, the multi-bit event is logged.
- R10: `nmi_o` equals bit 0 AND bit 2, and `serr_o` equals bit 1 AND bit 3. Both are levels that drop in the cycle after their flag is cleared.
- R11: Bits 31, 3 and 2 are read/write. Every write loads them from `wr_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Corrected (single-bit) error pulse from the checker |
| ue_i | input | 1 | Uncorrectable (multi-bit) error pulse from the checker |
| err_addr_i | input | ADDR_W (32) | Address of the failing read |
| err_syn_i | input | SYN_W (8) | Syndrome of the failing read |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register readback |
| scrub_req_o | output | 1 | One-cycle write-back scrub request |
| nmi_o | output | 1 | NMI request level |
| serr_o | output | 1 | System-error request level |

## Verification
The bench builds the block with its default parameters: a 32-bit address with 19 captured bits and an 8-bit syndrome. These sizes are small enough to sweep all 256 syndrome values. Each syndrome value also selects one of the eight control-bit settings and one of the four event kinds: none, single-bit, multi-bit, or both at once. Every pass then tries a later event while a flag is set, writes ones to the read-only fields, and clears the flags one at a time. This covers every pairing of flag with enable, and of scrub setting with event kind.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;
  localparam int unsigned FLAG_SBE_BIT = 0;
  localparam int unsigned FLAG_MBE_BIT = 1;
  localparam int unsigned NMI_EN_BIT   = 2;
  localparam int unsigned SERR_EN_BIT  = 3;
  localparam int unsigned SYN_LSB      = 4;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_SBE  = 2'd1,
    EV_MBE  = 2'd2
  } ev_kind_e;
endpackage

// File: rtl/ecc_err_ctrl.sv
module ecc_err_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic scrub_dis_d_i,
  input  logic nmi_en_d_i,
  input  logic serr_en_d_i,
  input  logic ce_i,
  output logic scrub_dis_o,
  output logic nmi_en_o,
  output logic serr_en_o,
  output logic scrub_req_o
);
  logic scrub_dis_q, nmi_en_q, serr_en_q, scrub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scrub_dis_q <= 1'b0;
      nmi_en_q    <= 1'b0;
      serr_en_q   <= 1'b0;
    end else if (wr_en_i) begin
      scrub_dis_q <= scrub_dis_d_i;
      nmi_en_q    <= nmi_en_d_i;
      serr_en_q   <= serr_en_d_i;
    end
  end

  // scrub follows every corrected read, independent of logging state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scrub_q <= 1'b0;
    else         scrub_q <= ce_i & ~scrub_dis_q;
  end

  assign scrub_dis_o = scrub_dis_q;
  assign nmi_en_o    = nmi_en_q;
  assign serr_en_o   = serr_en_q;
  assign scrub_req_o = scrub_q;

  assert_scrub_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scrub_q |=> !scrub_q || $past(ce_i));
  assert_scrub_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scrub_dis_q && !wr_en_i |=> !scrub_q);
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_err_pkg::*;
#(
  parameter int unsigned CAP_W = 19,
  parameter int unsigned SYN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             ue_i,
  input  logic [CAP_W-1:0] addr_i,
  input  logic [SYN_W-1:0] syn_i,
  input  logic             clr_sbe_i,
  input  logic             clr_mbe_i,
  output logic             sbe_o,
  output logic             mbe_o,
  output logic [CAP_W-1:0] addr_o,
  output logic [SYN_W-1:0] syn_o
);
  logic             sbe_q, mbe_q;
  logic [CAP_W-1:0] addr_q;
  logic [SYN_W-1:0] syn_q;
  ev_kind_e         kind;
  logic             armed;

  always_comb begin
    if (ue_i)      kind = EV_MBE;
    else if (ce_i) kind = EV_SBE;
    else           kind = EV_NONE;
  end

  assign armed = ~sbe_q & ~mbe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sbe_q  <= 1'b0;
      mbe_q  <= 1'b0;
      addr_q <= '0;
      syn_q  <= '0;
    end else if (armed) begin
      case (kind)
        EV_MBE: begin
          mbe_q  <= 1'b1;
          addr_q <= addr_i;
          syn_q  <= '0;
        end
        EV_SBE: begin
          sbe_q  <= 1'b1;
          addr_q <= addr_i;
          syn_q  <= syn_i;
        end
        default: ;
      endcase
    end else begin
      if (clr_sbe_i) sbe_q <= 1'b0;
      if (clr_mbe_i) mbe_q <= 1'b0;
    end
  end

  assign sbe_o  = sbe_q;
  assign mbe_o  = mbe_q;
  assign addr_o = addr_q;
  assign syn_o  = syn_q;

  assert_flags_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sbe_q && mbe_q));
  assert_fields_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |=> $stable(addr_q) && $stable(syn_q));
  assert_no_new_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sbe_q |=> !mbe_q);
  assert_mbe_syn_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mbe_q) |-> syn_q == '0);
  assert_mbe_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && ue_i && ce_i |=> mbe_q && !sbe_q);
  assert_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sbe_q && clr_sbe_i |=> !sbe_q);
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_err_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CAP_W  = 19,
  parameter int unsigned SYN_W  = 8,
  localparam int unsigned SYN_MSB = SYN_LSB + SYN_W - 1,
  localparam int unsigned ADR_LSB = SYN_MSB + 1,
  localparam int unsigned ADR_MSB = ADR_LSB + CAP_W - 1,
  localparam int unsigned DIS_BIT = ADR_MSB + 1,
  localparam int unsigned REG_W   = DIS_BIT + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              ue_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic [SYN_W-1:0]  err_syn_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              scrub_req_o,
  output logic              nmi_o,
  output logic              serr_o
);
  logic             scrub_dis, nmi_en, serr_en;
  logic             sbe, mbe;
  logic [CAP_W-1:0] cap_addr;
  logic [SYN_W-1:0] cap_syn;

  ecc_err_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .scrub_dis_d_i(wr_data_i[DIS_BIT]),
    .nmi_en_d_i   (wr_data_i[NMI_EN_BIT]),
    .serr_en_d_i  (wr_data_i[SERR_EN_BIT]),
    .ce_i         (ce_i),
    .scrub_dis_o  (scrub_dis),
    .nmi_en_o     (nmi_en),
    .serr_en_o    (serr_en),
    .scrub_req_o  (scrub_req_o)
  );

  ecc_err_capture #(.CAP_W(CAP_W), .SYN_W(SYN_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_i     (ce_i),
    .ue_i     (ue_i),
    .addr_i   (err_addr_i[ADDR_W-1 -: CAP_W]),
    .syn_i    (err_syn_i),
    .clr_sbe_i(wr_en_i & wr_data_i[FLAG_SBE_BIT]),
    .clr_mbe_i(wr_en_i & wr_data_i[FLAG_MBE_BIT]),
    .sbe_o    (sbe),
    .mbe_o    (mbe),
    .addr_o   (cap_addr),
    .syn_o    (cap_syn)
  );

  always_comb begin
    rd_data_o                   = '0;
    rd_data_o[DIS_BIT]          = scrub_dis;
    rd_data_o[ADR_MSB:ADR_LSB]  = cap_addr;
    rd_data_o[SYN_MSB:SYN_LSB]  = cap_syn;
    rd_data_o[SERR_EN_BIT]      = serr_en;
    rd_data_o[NMI_EN_BIT]       = nmi_en;
    rd_data_o[FLAG_MBE_BIT]     = mbe;
    rd_data_o[FLAG_SBE_BIT]     = sbe;
  end

  assign nmi_o  = sbe & nmi_en;
  assign serr_o = mbe & serr_en;

  assert_nmi_drops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sbe) |-> !nmi_o);
  assert_serr_drops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mbe) |-> !serr_o);
  assert_ctrl_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[DIS_BIT] == $past(wr_data_i[DIS_BIT]));
  assert_mutual_out_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nmi_o && serr_o));
endmodule

// File: tb/ecc_err_log_bench.sv
`timescale 1ns/1ps
module ecc_err_log_bench;
  localparam int CYC_LIMIT = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0, ue = 1'b0, wr = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [7:0]  syn = '0;
  logic [31:0] rd;
  logic        scrub, nmi, serr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic        m_dis = 0, m_nmi = 0, m_serr = 0, m_sbe = 0, m_mbe = 0, m_scrub = 0;
  logic [18:0] m_addr = '0;
  logic [7:0]  m_syn = '0;

  always #2.5 clk = ~clk;

  ecc_err_log u_ecc_err_log (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .ue_i(ue),
    .err_addr_i(addr), .err_syn_i(syn), .wr_en_i(wr), .wr_data_i(wdata),
    .rd_data_o(rd), .scrub_req_o(scrub), .nmi_o(nmi), .serr_o(serr)
  );

  function automatic logic [31:0] exp_word();
    return {m_dis, m_addr, m_syn, m_serr, m_nmi, m_mbe, m_sbe};
  endfunction

  task automatic chk(input string req);
    logic [34:0] act, exp;
    act = {rd, nmi, serr, scrub};
    exp = {exp_word(), m_sbe & m_nmi, m_mbe & m_serr, m_scrub};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rd/nmi/serr/scrub actual %h/%b/%b/%b expected %h/%b/%b/%b",
               req, rd, nmi, serr, scrub, exp[34:3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic do_err(input logic c, input logic u, input logic [31:0] a,
                        input logic [7:0] s);
    @(negedge clk);
    ce = c; ue = u; addr = a; syn = s;
    @(posedge clk);
    m_scrub = c & ~m_dis;
    if (!m_sbe && !m_mbe) begin
      if (u) begin m_mbe = 1; m_addr = a[31:13]; m_syn = '0; end
      else if (c) begin m_sbe = 1; m_addr = a[31:13]; m_syn = s; end
    end
    @(negedge clk);
    ce = 0; ue = 0;
  endtask

  task automatic do_wr(input logic [31:0] d);
    @(negedge clk);
    wr = 1; wdata = d;
    @(posedge clk);
    m_scrub = 0;
    m_dis = d[31]; m_nmi = d[2]; m_serr = d[3];
    if (d[0]) m_sbe = 0;
    if (d[1]) m_mbe = 0;
    @(negedge clk);
    wr = 0;
  endtask

  initial begin
    repeat (CYC_LIMIT) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1");
    for (int s = 0; s < 256; s++) begin
      logic [31:0] ctrl, a;
      logic [7:0]  sv;
      sv   = 8'(s);
      ctrl = {sv[0], 27'b0, sv[2], sv[1], 2'b00};
      a    = 32'(s) * 32'h9E37_79B9 + 32'h1234_5678;
      do_wr(ctrl | 32'h3);
      chk("R11");
      do_err(sv[3], sv[4], a, sv);
      case (sv[4:3])
        2'b00: chk("R5");
        2'b01: chk("R4");
        2'b10: chk("R8");
        default: chk("R9");
      endcase
      do_err(1'b1, 1'b0, ~a, ~sv);
      chk("R7");
      do_err(1'b0, 1'b1, a ^ 32'hFFFF_0000, sv ^ 8'h5A);
      chk("R7");
      do_wr(ctrl | 32'h7FFF_FFF0);
      chk("R3");
      do_wr(ctrl | 32'h1);
      chk("R6");
      do_wr(ctrl | 32'h2);
      chk("R10");
      do_err(1'b1, 1'b0, a + 32'h0000_2000, sv + 8'd1);
      chk("R2");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule